// File: doc/BRIEF.md
# Line-Locked Video Reference Timing Generator

This block derives the line and frame reference strobes for a digital video port. It runs from a line-locked clock at twice the sample rate. It counts positions within a line and lines within a frame, for either a 625-line or a 525-line standard. From that count it drives five outputs:

- a pixel qualifier that marks every second clock;
- an active-line reference;
- a horizontal sync whose two edges are set by configuration inputs;
- a vertical sync spanning a block of whole lines;
- an active-low reset indication, which stays low for a fixed number of clocks after reset ends.

The block has two reset sources, a system reset and a chip enable, and either one puts it into reset. The active-line reference, both syncs and their shared output enable stay low after reset until the enable input is raised. There is no tristate inside the block: a disabled reference output is driven low, and it is paired with an output-enable signal that goes to the pad logic. The horizontal sync edge settings and the standard select are captured only at line and frame boundaries. A setting that changes in mid-line therefore never produces a partial pulse.

Top module: `vid_ref_timing`

## Requirements
- R1: `rst_ind_n` is low while in reset. It first reads high after the (RST_HOLD+2)-th rising clock edge that follows the release of reset: 2 edges of synchronizer, then RST_HOLD counted clocks. It then stays high until the next reset.
- R2: `pix_qual` is low in reset. From the first counting edge onward it is high at every even clock position of the line (position 0 is even) and toggles on every clock, whatever the state of `out_en`.
- R3: a line lasts 2*SAMPLES_625 clocks when `std_525`=0 and 2*SAMPLES_525 clocks when `std_525`=1. The line length in force is the one of the frame that contains the line.
- R4: when enabled, `act_ref` is high from clock position 2*ACTIVE_START up to, but not including, position 2*(ACTIVE_START+ACTIVE_SAMPLES) on every line of the frame, including the vertical blanking lines.
- R5: the horizontal sync rise position is 8*`hs_rise_coarse` + 2*`hs_fine` and the fall position is 8*`hs_fall_coarse` + 2*`hs_fine`, both in clock positions. When enabled, `hsync` is high at positions p with rise <= p < fall. When rise > fall, it is high at p >= rise or p < fall. When rise = fall, it stays low. A position past the end of the line never occurs.
- R6: the horizontal sync settings are captured only on the first clock of each line. A change made during a line takes effect at the next line start.
- R7: when enabled, `vsync` is high for whole lines VS_START_LINE up to VS_START_LINE+VS_LINES-1 of each frame. Its edges fall at line position 0.
- R8: a frame holds LINES_625 lines when `std_525`=0 and LINES_525 lines when `std_525`=1. `std_525` is captured at the first clock of each frame, and a mid-frame change waits for the next frame.
- R9: `ref_oe` is low in reset and follows `out_en` one clock later while counting. While `ref_oe` is low, `act_ref`, `hsync` and `vsync` are low.
- R10: holding `chip_en` low resets the block exactly as `rst_n` low does. `rst_ind_n` and `pix_qual` go low, and after `chip_en` rises the R1 timing restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-locked clock, two clocks per sample |
| rst_n | input | 1 | Asynchronous active-low system reset |
| chip_en | input | 1 | Chip enable; low acts as reset |
| std_525 | input | 1 | Standard select: 0 = 625-line, 1 = 525-line |
| out_en | input | 1 | Enable for the reference outputs |
| hs_rise_coarse | input | C_W | Sync rise position in 8-clock steps |
| hs_fall_coarse | input | C_W | Sync fall position in 8-clock steps |
| hs_fine | input | 2 | Shift of both sync edges in 2-clock steps |
| rst_ind_n | output | 1 | Active-low reset indication |
| pix_qual | output | 1 | Half-rate pixel qualifier |
| act_ref | output | 1 | Active-line reference |
| hsync | output | 1 | Programmable horizontal sync |
| vsync | output | 1 | Vertical sync |
| ref_oe | output | 1 | Output enable for act_ref, hsync and vsync |

## Verification
Two functions can act on the same clock. The line wrap can coincide with a change of the sync edge settings, and the frame wrap can coincide with a change of the standard select. In both cases the new value must be taken for the new line or frame and not before. The bench holds each of 256 sync settings for 83 clocks, which is not a multiple of the line length. The setting changes therefore land at every phase of the line, including the wrap clock. The standard select is likewise toggled in mid-frame. The outputs are judged on every clock against a position model in the bench. That model captures settings only at its own line and frame starts. Line and frame periods are also measured from reference edge to reference edge.

// File: rtl/vrt_pkg.sv
package vrt_pkg;

  // Video standard selected for a frame.
  typedef enum logic {
    STD_625 = 1'b0,
    STD_525 = 1'b1
  } vrt_std_e;

  function automatic int unsigned vrt_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/vrt_rst_sync.sv
// Reset release synchronizer and reset-indication hold counter.
module vrt_rst_sync #(
  parameter int unsigned RST_HOLD = 128
) (
  input  logic clk,
  input  logic arst_n,
  output logic run,
  output logic rst_ind_n
);

  localparam int unsigned HW = $clog2(RST_HOLD + 1);
  localparam logic [HW-1:0] HOLD_END = HW'(RST_HOLD);

  logic          sync1_q;
  logic          sync2_q;
  logic [HW-1:0] hold_q;
  logic [HW-1:0] hold_d;
  logic          ind_q;
  logic          ind_d;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= 1'b1;
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    hold_d = hold_q;
    if (sync2_q && (hold_q != HOLD_END)) begin
      hold_d = hold_q + HW'(1);
    end
    ind_d = (hold_d == HOLD_END);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      hold_q <= '0;
      ind_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      ind_q  <= ind_d;
    end
  end

  assign run       = sync2_q;
  assign rst_ind_n = ind_q;

endmodule

// File: rtl/vrt_line_cnt.sv
// Position-in-line and line-in-frame counters with per-frame standard capture.
module vrt_line_cnt
  import vrt_pkg::*;
#(
  parameter int unsigned SAMPLES_625 = 864,
  parameter int unsigned SAMPLES_525 = 858,
  parameter int unsigned LINES_625   = 625,
  parameter int unsigned LINES_525   = 525,
  parameter int unsigned H_W         = 11,
  parameter int unsigned V_W         = 10
) (
  input  logic           clk,
  input  logic           arst_n,
  input  logic           run,
  input  vrt_std_e       std_sel,
  output logic [H_W-1:0] h_nxt,
  output logic [V_W-1:0] v_nxt,
  output logic           line_load
);

  localparam logic [H_W-1:0] H_LAST_625 = H_W'(2 * SAMPLES_625 - 1);
  localparam logic [H_W-1:0] H_LAST_525 = H_W'(2 * SAMPLES_525 - 1);
  localparam logic [V_W-1:0] V_LAST_625 = V_W'(LINES_625 - 1);
  localparam logic [V_W-1:0] V_LAST_525 = V_W'(LINES_525 - 1);

  logic           primed_q, primed_d;
  logic [H_W-1:0] h_q;
  logic [V_W-1:0] v_q;
  vrt_std_e       std_q, std_d;
  logic [H_W-1:0] h_last;
  logic [V_W-1:0] v_last;
  logic           line_end;
  logic           frame_end;

  always_comb begin
    h_last    = (std_q == STD_525) ? H_LAST_525 : H_LAST_625;
    v_last    = (std_q == STD_525) ? V_LAST_525 : V_LAST_625;
    line_end  = (h_q == h_last);
    frame_end = line_end && (v_q == v_last);
  end

  always_comb begin
    primed_d  = primed_q;
    h_nxt     = h_q;
    v_nxt     = v_q;
    std_d     = std_q;
    line_load = 1'b0;
    if (run) begin
      if (!primed_q || frame_end) begin
        primed_d  = 1'b1;
        h_nxt     = '0;
        v_nxt     = '0;
        std_d     = std_sel;
        line_load = 1'b1;
      end else if (line_end) begin
        h_nxt     = '0;
        v_nxt     = v_q + V_W'(1);
        line_load = 1'b1;
      end else begin
        h_nxt     = h_q + H_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      primed_q <= 1'b0;
      h_q      <= '0;
      v_q      <= '0;
      std_q    <= STD_625;
    end else if (run) begin
      primed_q <= primed_d;
      h_q      <= h_nxt;
      v_q      <= v_nxt;
      std_q    <= std_d;
    end
  end

endmodule

// File: rtl/vrt_hsync.sv
// Horizontal sync window with edge positions captured at line start.
module vrt_hsync #(
  parameter int unsigned H_W = 11,
  parameter int unsigned C_W = 8
) (
  input  logic           clk,
  input  logic           arst_n,
  input  logic           load,
  input  logic [C_W-1:0] rise_c,
  input  logic [C_W-1:0] fall_c,
  input  logic [1:0]     fine,
  input  logic [H_W-1:0] h_pos,
  output logic           win
);

  localparam int unsigned P_W = H_W + 1;

  logic [P_W-1:0] fine_off;
  logic [P_W-1:0] rise_calc, fall_calc;
  logic [P_W-1:0] rise_q, fall_q;
  logic [P_W-1:0] rise_u, fall_u;
  logic [P_W-1:0] hp;

  always_comb begin
    fine_off  = P_W'({fine, 1'b0});
    rise_calc = P_W'({rise_c, 3'b000}) + fine_off;
    fall_calc = P_W'({fall_c, 3'b000}) + fine_off;
    rise_u    = load ? rise_calc : rise_q;
    fall_u    = load ? fall_calc : fall_q;
    hp        = P_W'(h_pos);
    if (rise_u < fall_u) begin
      win = (hp >= rise_u) && (hp < fall_u);
    end else if (rise_u > fall_u) begin
      win = (hp >= rise_u) || (hp < fall_u);
    end else begin
      win = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rise_q <= '0;
      fall_q <= '0;
    end else if (load) begin
      rise_q <= rise_calc;
      fall_q <= fall_calc;
    end
  end

endmodule

// File: rtl/vid_ref_timing.sv
// Line-locked video reference timing generator, top level.
module vid_ref_timing
  import vrt_pkg::*;
#(
  parameter int unsigned SAMPLES_625    = 864,
  parameter int unsigned SAMPLES_525    = 858,
  parameter int unsigned LINES_625      = 625,
  parameter int unsigned LINES_525      = 525,
  parameter int unsigned ACTIVE_SAMPLES = 720,
  parameter int unsigned ACTIVE_START   = 132,
  parameter int unsigned VS_START_LINE  = 4,
  parameter int unsigned VS_LINES       = 6,
  parameter int unsigned RST_HOLD       = 128,
  localparam int unsigned H_W = $clog2(2 * vrt_max(SAMPLES_625, SAMPLES_525)),
  localparam int unsigned C_W = H_W - 3,
  localparam int unsigned V_W = $clog2(vrt_max(LINES_625, LINES_525))
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           chip_en,
  input  logic           std_525,
  input  logic           out_en,
  input  logic [C_W-1:0] hs_rise_coarse,
  input  logic [C_W-1:0] hs_fall_coarse,
  input  logic [1:0]     hs_fine,
  output logic           rst_ind_n,
  output logic           pix_qual,
  output logic           act_ref,
  output logic           hsync,
  output logic           vsync,
  output logic           ref_oe
);

  localparam logic [31:0] H_ON  = 32'(2 * ACTIVE_START);
  localparam logic [31:0] H_OFF = 32'(2 * (ACTIVE_START + ACTIVE_SAMPLES));
  localparam logic [31:0] V_ON  = 32'(VS_START_LINE);
  localparam logic [31:0] V_OFF = 32'(VS_START_LINE + VS_LINES);

  logic           arst_n;
  logic           run;
  logic [H_W-1:0] h_nxt;
  logic [V_W-1:0] v_nxt;
  logic           line_load;
  logic           hs_win;
  logic           act_win, vs_win;
  logic [31:0]    h_ext, v_ext;
  logic           qual_d, act_d, hs_d, vs_d, oe_d;
  logic           qual_q, act_q, hs_q, vs_q, oe_q;

  assign arst_n = rst_n & chip_en;

  vrt_rst_sync #(
    .RST_HOLD(RST_HOLD)
  ) u_rst (
    .clk      (clk),
    .arst_n   (arst_n),
    .run      (run),
    .rst_ind_n(rst_ind_n)
  );

  vrt_line_cnt #(
    .SAMPLES_625(SAMPLES_625),
    .SAMPLES_525(SAMPLES_525),
    .LINES_625  (LINES_625),
    .LINES_525  (LINES_525),
    .H_W        (H_W),
    .V_W        (V_W)
  ) u_cnt (
    .clk      (clk),
    .arst_n   (arst_n),
    .run      (run),
    .std_sel  (vrt_std_e'(std_525)),
    .h_nxt    (h_nxt),
    .v_nxt    (v_nxt),
    .line_load(line_load)
  );

  vrt_hsync #(
    .H_W(H_W),
    .C_W(C_W)
  ) u_hs (
    .clk   (clk),
    .arst_n(arst_n),
    .load  (line_load),
    .rise_c(hs_rise_coarse),
    .fall_c(hs_fall_coarse),
    .fine  (hs_fine),
    .h_pos (h_nxt),
    .win   (hs_win)
  );

  // Decode of the next position into the reference windows.
  always_comb begin
    h_ext   = 32'(h_nxt);
    v_ext   = 32'(v_nxt);
    act_win = (h_ext >= H_ON) && (h_ext < H_OFF);
    vs_win  = (v_ext >= V_ON) && (v_ext < V_OFF);
    qual_d  = ~h_nxt[0];
    act_d   = act_win & out_en;
    hs_d    = hs_win  & out_en;
    vs_d    = vs_win  & out_en;
    oe_d    = out_en;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      qual_q <= 1'b0;
      act_q  <= 1'b0;
      hs_q   <= 1'b0;
      vs_q   <= 1'b0;
      oe_q   <= 1'b0;
    end else if (run) begin
      qual_q <= qual_d;
      act_q  <= act_d;
      hs_q   <= hs_d;
      vs_q   <= vs_d;
      oe_q   <= oe_d;
    end
  end

  assign pix_qual = qual_q;
  assign act_ref  = act_q;
  assign hsync    = hs_q;
  assign vsync    = vs_q;
  assign ref_oe   = oe_q;

endmodule

// File: rtl/vrt_ref_timing_chk.sv
// Property checker for vid_ref_timing, attached by bind.
module vrt_ref_timing_chk #(
  parameter int unsigned ACTIVE_SAMPLES = 720
) (
  input logic clk,
  input logic rst_n,
  input logic chip_en,
  input logic out_en,
  input logic rst_ind_n,
  input logic pix_qual,
  input logic act_ref,
  input logic hsync,
  input logic vsync,
  input logic ref_oe
);

  localparam int unsigned ACT_LLC = 2 * ACTIVE_SAMPLES;
  localparam int unsigned CW      = $clog2(ACT_LLC + 2);

  logic          arst_n;
  logic [CW-1:0] run_len;
  logic          act_prev, oe_prev, clean;

  assign arst_n = rst_n & chip_en;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      run_len  <= '0;
      act_prev <= 1'b0;
      oe_prev  <= 1'b0;
      clean    <= 1'b0;
    end else begin
      act_prev <= act_ref;
      oe_prev  <= ref_oe;
      if (act_ref) begin
        if (run_len != CW'(ACT_LLC + 1)) run_len <= run_len + CW'(1);
      end else begin
        run_len <= '0;
      end
      if (act_ref && !act_prev) clean <= oe_prev;
    end
  end

  assert_ind_sticky_R1: assert property (@(posedge clk) disable iff (!arst_n)
    rst_ind_n |=> rst_ind_n);

  assert_qual_toggle_R2: assert property (@(posedge clk) disable iff (!arst_n)
    rst_ind_n |-> (pix_qual != $past(pix_qual)));

  assert_act_len_R4: assert property (@(posedge clk) disable iff (!arst_n)
    (act_prev && !act_ref && clean && ref_oe) |-> (run_len == CW'(ACT_LLC)));

  assert_vs_rise_R7: assert property (@(posedge clk) disable iff (!arst_n)
    ($rose(vsync) && $past(ref_oe)) |-> pix_qual);

  assert_vs_fall_R7: assert property (@(posedge clk) disable iff (!arst_n)
    ($fell(vsync) && ref_oe) |-> pix_qual);

  assert_oe_follow_R9: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(ref_oe) |-> $past(out_en));

  assert_gated_R9: assert property (@(posedge clk) disable iff (!arst_n)
    !ref_oe |-> !(act_ref || hsync || vsync));

  assert_ce_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |-> (!rst_ind_n && !pix_qual && !ref_oe));

endmodule

bind vid_ref_timing vrt_ref_timing_chk #(
  .ACTIVE_SAMPLES(ACTIVE_SAMPLES)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .chip_en  (chip_en),
  .out_en   (out_en),
  .rst_ind_n(rst_ind_n),
  .pix_qual (pix_qual),
  .act_ref  (act_ref),
  .hsync    (hsync),
  .vsync    (vsync),
  .ref_oe   (ref_oe)
);

// File: tb/vid_ref_timing_test.sv
module vid_ref_timing_test;

  localparam int S625 = 20;
  localparam int S525 = 18;
  localparam int N625 = 7;
  localparam int N525 = 6;
  localparam int ACT  = 12;
  localparam int AST  = 4;
  localparam int VST  = 2;
  localparam int VLN  = 3;
  localparam int HOLD = 10;

  logic       clk = 1'b0;
  logic       rst_n, chip_en, std_525, out_en;
  logic [2:0] rc, fc;
  logic [1:0] fine;
  logic       rst_ind_n, pix_qual, act_ref, hsync, vsync, ref_oe;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // Bench model state.
  int rel = 0, mh = 0, mv = 0, mhold = 0, mrise = 0, mfall = 0;
  bit mstd = 1'b0, men = 1'b0, mprim = 1'b0;
  // Interval measurement.
  int samp = 0, last_line = 0, line_exp = 0, last_fr = 0;
  bit line_valid = 1'b0, fr_valid = 1'b0, fr_std = 1'b0;
  bit prev_act = 1'b0, prev_vs = 1'b0, prev_oe = 1'b0;

  vid_ref_timing #(
    .SAMPLES_625(S625), .SAMPLES_525(S525), .LINES_625(N625), .LINES_525(N525),
    .ACTIVE_SAMPLES(ACT), .ACTIVE_START(AST), .VS_START_LINE(VST),
    .VS_LINES(VLN), .RST_HOLD(HOLD)
  ) uut (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .std_525(std_525), .out_en(out_en),
    .hs_rise_coarse(rc), .hs_fall_coarse(fc), .hs_fine(fine),
    .rst_ind_n(rst_ind_n), .pix_qual(pix_qual), .act_ref(act_ref),
    .hsync(hsync), .vsync(vsync), .ref_oe(ref_oe)
  );

  always #4ns clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit hs_exp(input int h, input int r, input int f);
    if (r < f) return (h >= r) && (h < f);
    if (r > f) return (h >= r) || (h < f);
    return 1'b0;
  endfunction

  task automatic latch_hs();
    mrise = 8 * int'(rc) + 2 * int'(fine);
    mfall = 8 * int'(fc) + 2 * int'(fine);
  endtask

  // Advance the model as a rising edge does.
  task automatic edge_model();
    int llen, flen;
    if (!(rst_n && chip_en)) begin
      rel = 0; mprim = 1'b0; mhold = 0; men = 1'b0; mh = 0; mv = 0;
    end else begin
      rel++;
      if (rel >= 3) begin
        men = out_en;
        if (mhold < HOLD) mhold++;
        llen = 2 * (mstd ? S525 : S625);
        flen = mstd ? N525 : N625;
        if (!mprim) begin
          mprim = 1'b1; mh = 0; mv = 0; mstd = std_525; latch_hs();
        end else if (mh == llen - 1) begin
          mh = 0;
          if (mv == flen - 1) begin
            mv = 0; mstd = std_525;
          end else begin
            mv++;
          end
          latch_hs();
        end else begin
          mh++;
        end
      end
    end
  endtask

  task automatic check_all();
    bit e_act, e_hs, e_vs;
    samp++;
    e_act = men && (mh >= 2 * AST) && (mh < 2 * (AST + ACT));
    e_hs  = men && hs_exp(mh, mrise, mfall);
    e_vs  = men && (mv >= VST) && (mv < VST + VLN);
    chk("R1 rst_ind_n", int'(rst_ind_n), int'(mhold == HOLD));
    chk("R2 pix_qual", int'(pix_qual), int'(mprim && (mh % 2 == 0)));
    chk("R4 act_ref", int'(act_ref), int'(e_act));
    chk("R5 R6 hsync", int'(hsync), int'(e_hs));
    chk("R7 vsync", int'(vsync), int'(e_vs));
    chk("R9 ref_oe", int'(ref_oe), int'(men));
    if (!(rst_n && chip_en) || !ref_oe) begin
      line_valid = 1'b0; fr_valid = 1'b0;
    end else begin
      if (act_ref && !prev_act && prev_oe) begin
        if (line_valid) chk("R3 line period", samp - last_line, line_exp);
        line_valid = 1'b1; last_line = samp;
        line_exp = 2 * (mstd ? S525 : S625);
      end
      if (vsync && !prev_vs && prev_oe) begin
        if (fr_valid && fr_std == mstd)
          chk("R8 frame period", samp - last_fr,
              2 * (mstd ? S525 * N525 : S625 * N625));
        fr_valid = 1'b1; fr_std = mstd; last_fr = samp;
      end
    end
    prev_act = act_ref; prev_vs = vsync; prev_oe = ref_oe;
  endtask

  task automatic cycle();
    @(posedge clk);
    edge_model();
    @(negedge clk);
    check_all();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic wait_ind(input string tag);
    int n = 0;
    do begin
      cycle();
      n++;
    end while (!rst_ind_n && n < 100);
    chk(tag, n, HOLD + 2);
  endtask

  initial begin
    rst_n = 1'b0; chip_en = 1'b1; std_525 = 1'b0; out_en = 1'b0;
    rc = 3'd0; fc = 3'd0; fine = 2'd0;
    @(negedge clk);
    run(5);                               // reset state: R1 R2 R9
    rst_n = 1'b1;
    wait_ind("R1 release to indication edges");
    run(60);                              // disabled outputs stay low: R9
    out_en = 1'b1; rc = 3'd1; fc = 3'd3;
    run(2 * 2 * S625 * N625);             // R3 R4 R7 R8
    // Sweep of all sync settings, dwell not a multiple of the line: R5 R6
    for (int r = 0; r < 8; r++)
      for (int f = 0; f < 8; f++)
        for (int k = 0; k < 4; k++) begin
          rc = 3'(r); fc = 3'(f); fine = 2'(k);
          run(83);
        end
    rc = 3'd4; fc = 3'd1; fine = 2'd1;
    run(37);
    std_525 = 1'b1;                       // mid-frame change: R8 R3
    run(3 * 2 * S625 * N625);
    for (int i = 0; i < 6; i++) begin     // enable toggles mid-line: R9
      out_en = ~out_en;
      run(13 + 7 * i);
    end
    out_en = 1'b1;
    run(100);
    chip_en = 1'b0;                       // chip enable as reset: R10
    cycle();
    chk("R10 indication low with chip_en low", int'(rst_ind_n), 0);
    chk("R10 qualifier low with chip_en low", int'(pix_qual), 0);
    run(4);
    chip_en = 1'b1;
    wait_ind("R10 R1 indication after chip_en rise");
    run(2 * 2 * S525 * N525);
    std_525 = 1'b0;
    rst_n = 1'b0;
    run(3);
    std_525 = 1'b1;
    rst_n = 1'b1;
    run(2 * 2 * S525 * N525 + 50);        // first frame takes std at start: R8
    std_525 = 1'b0;
    run(3 * 2 * S625 * N625);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule